// File: doc/BRIEF.md
# RTC Time-of-Day and Calendar Counter

This block keeps wall-clock time and date for a real-time clock. A fast enable, `tick_in`, arrives at a fixed rate from an oscillator divider. A prescaler counts `TICKS_PER_SEC` of these pulses to make one second. Each second then ripples through seconds, minutes, hours, day of month, month and a two-digit year. Every field is held and presented in packed BCD.

The hours register carries its own format. Bit 7 selects 24-hour counting when set and 12-hour counting when clear. In 12-hour form, bit 5 flags PM and bits 4:0 hold the hour 01..12. In 24-hour form, bits 5:0 hold 00..23. Month lengths follow the calendar. February gets a 29th day in any year whose two-digit value is a multiple of four, and year 00 counts as such a year.

Software sets the time through a load port with a valid/ready handshake. `ld_ready` is held high at all times, so the port never applies back-pressure. Every cycle in which `ld_valid` is high writes one field. Writing a field also restarts the sub-second phase, so the first second after a write is a full second.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the outputs are sec=00, min=00, hour=8'h12 (12-hour mode, AM, hour 12), day=01, month=01, year=00, and `ld_ready` is 1.
- R2: The seconds field advances by one after exactly `TICKS_PER_SEC` cycles with `tick_in` high since the last reset or field load, and changes in no cycle where `tick_in` is low.
- R3: Seconds and minutes count 00..59 in BCD. The step from 59 to 00 advances the next field by one.
- R4: With hour bit 7 set, the hours count 8'h80..8'hA3 (00..23 plus the mode bit). The step from 23 to 00 advances the day.
- R5: With hour bit 7 clear, the hours in bits 4:0 run 12, 01, 02 .. 11, 12. Bit 5 (PM) toggles only on the step from 11 to 12. The step from 11 PM to 12 AM advances the day.
- R6: The day of month runs up to 31 for months 01, 03, 05, 07, 08, 10 and 12, and up to 30 for months 04, 06, 09 and 11. It then returns to 01 and advances the month.
- R7: February runs to 29 when the year value is divisible by 4 (00 included) and to 28 otherwise.
- R8: Month 12 returns to 01 and advances the year. Year 99 returns to 00.
- R9: A cycle with `ld_valid`=1 writes `ld_data` into the field chosen by `ld_sel` (0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year) and leaves every other field unchanged. A write to the hour field stores bit 6 as 0. The `ld_sel` values 6 and 7 change nothing.
- R10: A field write in the same cycle as the second-completing `tick_in` wins: the written value appears, no second is counted, and a full `TICKS_PER_SEC` ticks are needed for the next second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Sub-second enable from the oscillator divider |
| ld_valid | input | 1 | Field write request |
| ld_ready | output | 1 | Write accept, always 1 |
| ld_sel | input | 3 | Field select: 0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year |
| ld_data | input | 8 | BCD value to write (hour: bit 7 mode, bit 5 PM) |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours register with mode and PM bits |
| day | output | 8 | Day of month, BCD |
| month | output | 8 | Month, BCD |
| year | output | 8 | Year 00..99, BCD |

## Verification
Each case presets the fields to a point just before a rollover and then applies one second of ticks. Midnight in 24-hour mode with the last day of December in year 99 exercises the whole carry chain at once. The 12-hour steps 11 AM→12 PM, 11 PM→12 AM and 12 PM→01 PM separate the PM toggle from the day carry. February 28 across years 24, 23, 00, 10 and 12 separates the divisible-by-4 rule from a plain ones-digit test. Short tick bursts around a simultaneous write show whether the phase restarts and whether the write wins over the second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DAY   = 3'd3,
    SEL_MONTH = 3'd4,
    SEL_YEAR  = 3'd5
  } field_sel_e;

  // Add one to a two-digit packed BCD value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Two-digit packed BCD to binary.
  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic clear,
  output logic sec_stb
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] phase;
  logic          at_last;

  assign at_last = (phase == LAST);
  assign sec_stb = tick_in && at_last && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) phase <= '0;
    else if (tick_in)    phase <= at_last ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/rtc_mod_counter.sv
module rtc_mod_counter #(
  parameter logic [7:0] LAST = 8'h59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] ld_data,
  input  logic       step,
  output logic [7:0] value,
  output logic       carry
);
  import rtc_pkg::*;

  assign carry = step && (value == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    value <= 8'h00;
    else if (load) value <= ld_data;
    else if (step) value <= carry ? 8'h00 : bcd_inc(value);
  end
endmodule

// File: rtl/rtc_hour_unit.sv
module rtc_hour_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] ld_data,
  input  logic       step,
  output logic [7:0] hour,
  output logic       carry
);
  import rtc_pkg::*;

  logic [7:0] nxt;
  logic [7:0] inc;
  logic       wrap;

  always_comb begin
    nxt  = hour;
    wrap = 1'b0;
    inc  = 8'h00;
    if (hour[7]) begin
      // 24-hour: bits 5:0 hold 00..23
      if (hour[5:0] == 6'h23) begin
        nxt  = 8'h80;
        wrap = 1'b1;
      end else begin
        inc = bcd_inc({2'b00, hour[5:0]});
        nxt = {2'b10, inc[5:0]};
      end
    end else begin
      // 12-hour: bit 5 is PM, bits 4:0 hold 01..12
      if (hour[4:0] == 5'h12) begin
        nxt = {2'b00, hour[5], 5'h01};
      end else if (hour[4:0] == 5'h11) begin
        nxt  = {2'b00, ~hour[5], 5'h12};
        wrap = hour[5];
      end else begin
        inc = bcd_inc({3'b000, hour[4:0]});
        nxt = {2'b00, hour[5], inc[4:0]};
      end
    end
  end

  assign carry = step && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)    hour <= 8'h12;
    else if (load) hour <= {ld_data[7], 1'b0, ld_data[5:0]};
    else if (step) hour <= nxt;
  end
endmodule

// File: rtl/rtc_date_unit.sv
module rtc_date_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_day,
  input  logic       ld_month,
  input  logic       ld_year,
  input  logic [7:0] ld_data,
  input  logic       step,
  output logic [7:0] day,
  output logic [7:0] month,
  output logic [7:0] year
);
  import rtc_pkg::*;

  logic [7:0] year_bin;
  logic       leap;
  logic [7:0] last_day;
  logic       day_wrap;
  logic       mon_wrap;

  assign year_bin = bcd_to_bin(year);
  assign leap     = (year_bin % 8'd4) == 8'd0;

  always_comb begin
    case (bcd_to_bin(month))
      8'd2:                      last_day = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   last_day = 8'd30;
      default:                   last_day = 8'd31;
    endcase
  end

  assign day_wrap = step && (bcd_to_bin(day) == last_day);
  assign mon_wrap = day_wrap && (month == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day   <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
    end else begin
      if (ld_day)        day <= ld_data;
      else if (step)     day <= day_wrap ? 8'h01 : bcd_inc(day);

      if (ld_month)      month <= ld_data;
      else if (day_wrap) month <= mon_wrap ? 8'h01 : bcd_inc(month);

      if (ld_year)       year <= ld_data;
      else if (mon_wrap) year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       ld_valid,
  output logic       ld_ready,
  input  logic [2:0] ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] day,
  output logic [7:0] month,
  output logic [7:0] year
);
  import rtc_pkg::*;

  localparam int NCNT = 2;  // seconds, minutes

  logic            ld_hit;
  logic            sec_stb;
  logic            hour_carry;
  logic [NCNT-1:0] cnt_ld;
  logic [NCNT-1:0] cnt_step;
  logic [NCNT-1:0] cnt_carry;
  logic [7:0]      cnt_val [NCNT];

  assign ld_ready = 1'b1;
  assign ld_hit   = ld_valid && (ld_sel <= SEL_YEAR);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_in),
    .clear   (ld_hit),
    .sec_stb (sec_stb)
  );

  assign cnt_ld[0] = ld_valid && (ld_sel == SEL_SEC);
  assign cnt_ld[1] = ld_valid && (ld_sel == SEL_MIN);
  assign cnt_step  = {cnt_carry[NCNT-2:0], sec_stb};

  for (genvar g = 0; g < NCNT; g++) begin : g_ms
    rtc_mod_counter #(.LAST(8'h59)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cnt_ld[g]),
      .ld_data (ld_data),
      .step    (cnt_step[g]),
      .value   (cnt_val[g]),
      .carry   (cnt_carry[g])
    );
  end

  assign sec = cnt_val[0];
  assign min = cnt_val[1];

  rtc_hour_unit u_hour (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld_valid && (ld_sel == SEL_HOUR)),
    .ld_data (ld_data),
    .step    (cnt_carry[NCNT-1]),
    .hour    (hour),
    .carry   (hour_carry)
  );

  rtc_date_unit u_date (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_day   (ld_valid && (ld_sel == SEL_DAY)),
    .ld_month (ld_valid && (ld_sel == SEL_MONTH)),
    .ld_year  (ld_valid && (ld_sel == SEL_YEAR)),
    .ld_data  (ld_data),
    .step     (hour_carry),
    .day      (day),
    .month    (month),
    .year     (year)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_in,
  input logic       ld_valid,
  input logic [2:0] ld_sel,
  input logic [7:0] ld_data,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] day,
  input logic [7:0] month,
  input logic [7:0] year
);
  logic [7:0] yr_val;
  logic       yr_leap;
  assign yr_val  = 8'(year[7:4]) * 8'd10 + 8'(year[3:0]);
  assign yr_leap = (yr_val % 8'd4) == 8'd0;

  assert_sec_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_valid && !tick_in) |=> $stable(sec));

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec == 8'h59 && !ld_valid) |=> (sec == 8'h59 || sec == 8'h00));

  assert_hour24_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hour == 8'hA3 && !ld_valid) |=> (hour == 8'hA3 || hour == 8'h80));

  assert_pm_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hour[7] && hour[4:0] == 5'h11 && !ld_valid) |=>
      ((hour[4:0] == 5'h11) ? (hour[5] == $past(hour[5])) : (hour[5] != $past(hour[5]))));

  assert_april_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (month == 8'h04 && day == 8'h30 && !ld_valid) |=> (day == 8'h30 || day == 8'h01));

  assert_feb_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (month == 8'h02 && day == 8'h28 && !yr_leap && !ld_valid) |=> (day != 8'h29));

  assert_year_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (year == 8'h99 && !ld_valid) |=> (year == 8'h99 || year == 8'h00));

  assert_sec_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_sel == 3'd0) |=> (sec == $past(ld_data)));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_sel == 3'd0) |=> $stable(min));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_in  (tick_in),
  .ld_valid (ld_valid),
  .ld_sel   (ld_sel),
  .ld_data  (ld_data),
  .sec      (sec),
  .min      (min),
  .hour     (hour),
  .day      (day),
  .month    (month),
  .year     (year)
);

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic       ld_valid = 1'b0;
  logic       ld_ready;
  logic [2:0] ld_sel = 3'd0;
  logic [7:0] ld_data = 8'h00;
  logic [7:0] sec, min, hour, day, month, year;

  always #4 clk = ~clk;  // 125 MHz

  rtc_calendar #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_sel(ld_sel), .ld_data(ld_data),
    .sec(sec), .min(min), .hour(hour), .day(day), .month(month), .year(year)
  );

  typedef struct {
    logic [7:0] s, m, h, d, mo, y;
    string      tag;
  } exp_t;

  exp_t q[$];
  event item_ev;
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;

  // Monitor: compares every queued expectation against the outputs.
  initial begin
    forever begin
      @(item_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if ({sec, min, hour, day, month, year} != {e.s, e.m, e.h, e.d, e.mo, e.y}) begin
          n_fails++;
          $display("FAIL %s: got %h:%h:%h %h/%h/%h exp %h:%h:%h %h/%h/%h", e.tag,
                   hour, min, sec, day, month, year, e.h, e.m, e.s, e.d, e.mo, e.y);
        end
      end
    end
  end

  task automatic expect_st(input logic [7:0] s, m, h, d, mo, y, input string tag);
    exp_t e;
    e.s = s; e.m = m; e.h = h; e.d = d; e.mo = mo; e.y = y; e.tag = tag;
    q.push_back(e);
    -> item_ev;
    #1;
  endtask

  task automatic write_field(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = sel; ld_data = data;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic write_with_tick(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = sel; ld_data = data; tick_in = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0; tick_in = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
  endtask

  task automatic set_all(input logic [7:0] s, m, h, d, mo, y);
    write_field(3'd0, s);
    write_field(3'd1, m);
    write_field(3'd2, h);
    write_field(3'd3, d);
    write_field(3'd4, mo);
    write_field(3'd5, y);
  endtask

  // Preset to hh:59:59 on a date, then run one full second.
  task automatic one_sec_from(input logic [7:0] h, d, mo, y);
    set_all(8'h59, 8'h59, h, d, mo, y);
    ticks(TPS);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and ready
    expect_st(8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, "R1 reset state");
    n_checks++;
    if (ld_ready !== 1'b1) begin
      n_fails++;
      $display("FAIL R1 ld_ready: got %b exp 1", ld_ready);
    end

    // R2: seconds need exactly TPS ticks
    ticks(TPS - 1);
    expect_st(8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, "R2 short of a second");
    ticks(1);
    expect_st(8'h01, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, "R2 one second");
    repeat (5) @(negedge clk);
    expect_st(8'h01, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, "R2 idle without ticks");

    // R10: write on the second-completing tick wins and restarts the phase
    ticks(TPS - 1);
    write_with_tick(3'd0, 8'h30);
    expect_st(8'h30, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, "R10 write beats tick");
    ticks(TPS - 1);
    expect_st(8'h30, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, "R10 phase restarted");
    ticks(1);
    expect_st(8'h31, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, "R10 full second later");

    // R3 R4 R8: whole chain rolls over at once
    one_sec_from(8'hA3, 8'h31, 8'h12, 8'h99);
    expect_st(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, "R3 R4 R8 full rollover");

    // R3: minute carry without hour wrap, and R4 BCD hour carry
    one_sec_from(8'h89, 8'h10, 8'h05, 8'h20);
    expect_st(8'h00, 8'h00, 8'h90, 8'h10, 8'h05, 8'h20, "R4 09 to 10 in 24h");

    // R5: 12-hour sequence
    one_sec_from(8'h11, 8'h15, 8'h03, 8'h21);
    expect_st(8'h00, 8'h00, 8'h32, 8'h15, 8'h03, 8'h21, "R5 11AM to 12PM");
    one_sec_from(8'h31, 8'h15, 8'h03, 8'h21);
    expect_st(8'h00, 8'h00, 8'h12, 8'h16, 8'h03, 8'h21, "R5 11PM to 12AM next day");
    one_sec_from(8'h32, 8'h15, 8'h03, 8'h21);
    expect_st(8'h00, 8'h00, 8'h21, 8'h15, 8'h03, 8'h21, "R5 12PM to 01PM");
    one_sec_from(8'h09, 8'h15, 8'h03, 8'h21);
    expect_st(8'h00, 8'h00, 8'h10, 8'h15, 8'h03, 8'h21, "R5 09AM to 10AM");

    // R6: month lengths
    one_sec_from(8'hA3, 8'h30, 8'h04, 8'h21);
    expect_st(8'h00, 8'h00, 8'h80, 8'h01, 8'h05, 8'h21, "R6 April ends at 30");
    one_sec_from(8'hA3, 8'h30, 8'h05, 8'h21);
    expect_st(8'h00, 8'h00, 8'h80, 8'h31, 8'h05, 8'h21, "R6 May has 31");

    // R7: February
    one_sec_from(8'hA3, 8'h28, 8'h02, 8'h24);
    expect_st(8'h00, 8'h00, 8'h80, 8'h29, 8'h02, 8'h24, "R7 year 24 leap");
    one_sec_from(8'hA3, 8'h28, 8'h02, 8'h23);
    expect_st(8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h23, "R7 year 23 common");
    one_sec_from(8'hA3, 8'h28, 8'h02, 8'h00);
    expect_st(8'h00, 8'h00, 8'h80, 8'h29, 8'h02, 8'h00, "R7 year 00 leap");
    one_sec_from(8'hA3, 8'h29, 8'h02, 8'h00);
    expect_st(8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h00, "R7 leap Feb ends at 29");
    one_sec_from(8'hA3, 8'h28, 8'h02, 8'h10);
    expect_st(8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h10, "R7 year 10 common");
    one_sec_from(8'hA3, 8'h28, 8'h02, 8'h12);
    expect_st(8'h00, 8'h00, 8'h80, 8'h29, 8'h02, 8'h12, "R7 year 12 leap");

    // R8: December to January without year 99
    one_sec_from(8'hA3, 8'h31, 8'h12, 8'h45);
    expect_st(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h46, "R8 new year");

    // R9: field writes, unused selects, hour bit 6
    set_all(8'h12, 8'h34, 8'h95, 8'h07, 8'h08, 8'h09);
    expect_st(8'h12, 8'h34, 8'h95, 8'h07, 8'h08, 8'h09, "R9 all fields written");
    write_field(3'd6, 8'h55);
    write_field(3'd7, 8'h66);
    expect_st(8'h12, 8'h34, 8'h95, 8'h07, 8'h08, 8'h09, "R9 selects 6 and 7 ignored");
    write_field(3'd2, 8'hD5);
    expect_st(8'h12, 8'h34, 8'h95, 8'h07, 8'h08, 8'h09, "R9 hour bit 6 cleared");
    write_field(3'd1, 8'h47);
    expect_st(8'h12, 8'h47, 8'h95, 8'h07, 8'h08, 8'h09, "R9 single field write");

    finish_run();
  end
endmodule